// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes written by a host into an asynchronous serial bit stream. Each character is framed as a low start level, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then a marking stop period of 1, 1.5 or 2 bit times. The line idles high. A single-cycle enable pulse at sixteen times the bit rate times every bit. A baud divider outside the block supplies that pulse.

Written bytes wait in a transmit buffer. Its depth depends on a mode input: one holding entry, or a first-in first-out queue of `DEPTH` entries. With automatic clear-to-send enabled, a new character starts only while the `cts` input is high. A character already on the line always runs to its end. A break input holds the line at the spacing level. Two flags tell the host when the buffer has drained and when the whole transmitter has gone quiet.

Top module: `async_tx`

## Requirements
- R1: During and right after reset, `tx_out` is 1, `thr_empty` is 1 and `tsr_empty` is 1, and the line stays at 1 whenever the transmitter is quiet and no break is forced.
- R2: A character is one start slot at 0, then N data bits least significant bit first, where N = 5 + `len_code` (code 0..3 gives 5..8 bits). Every slot lasts exactly 16 `tick16` pulses, and the line changes only on a tick or when a character is started.
- R3: With `par_en`=1, one parity slot follows the data. With `par_even`=1 it makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd. With `par_en`=0 no parity slot is sent.
- R4: The stop period is marking for 16 ticks when `stop_sel`=0, 24 ticks when `stop_sel`=1, and 32 ticks when `stop_sel` is 2 or 3. When further bytes are queued, the next start slot follows the stop period with no extra idle tick.
- R5: With `fifo_mode`=0 the buffer holds one byte. With `fifo_mode`=1 it holds `DEPTH` bytes, sent in write order. A write to a full buffer is dropped. A write in the same cycle as the transmitter takes a byte is accepted.
- R6: With `cts_auto_en`=1, no character starts while `cts` is 0, and one starts once `cts` returns to 1. With `cts_auto_en`=0, `cts` has no effect.
- R7: If `cts` drops while a character is on the line, that character completes, and the next queued character is held.
- R8: While `brk` is 1, `tx_out` is 0 in the same cycle, whatever the transmitter state.
- R9: `thr_empty` is 1 exactly when the buffer is empty, and falls one clock after an accepted write. `tsr_empty` is 1 only when the buffer is empty and no character is on the line. It rises one clock after the last stop tick.
- R10: Character length, parity and stop settings are captured when a character starts. Changing them during that character does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | W | Byte to transmit |
| fifo_mode | input | 1 | 0: single holding entry, 1: DEPTH-entry queue |
| len_code | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity slot present |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| stop_sel | input | 2 | 0: 1 stop bit, 1: 1.5 stop bits, 2/3: 2 stop bits |
| brk | input | 1 | Force spacing level on the line |
| cts | input | 1 | Clear to send, active high |
| cts_auto_en | input | 1 | Enables gating of character starts by cts |
| tx_out | output | 1 | Serial output line |
| thr_empty | output | 1 | Transmit buffer empty |
| tsr_empty | output | 1 | Buffer empty and no character on the line |

## Verification
When the transmitter is idle, a write sampled at one edge shows on `thr_empty` after that edge. The start level appears on `tx_out` one edge later. From then on, every slot lasts a number of ticks, not clocks, and `tsr_empty` rises on the edge that ends the last stop tick. The bench changes inputs just after a rising edge and reads outputs on the falling edge. Its line monitor takes one sample per tick, on the falling edge while `tick16` is high, so the sample is the value that tick consumes. Slot widths and stop gaps are therefore counted in ticks and do not depend on the tick spacing, which the bench varies.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  // framer phases of one character
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;

  // line settings captured at character start
  typedef struct packed {
    logic [1:0] len_code;   // data bits = 5 + len_code
    logic       par_en;
    logic       par_even;
    logic [1:0] stop_sel;   // 0: 1, 1: 1.5, 2/3: 2 stop bits
  } line_cfg_t;

endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         deep_mode,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, accept, take;

  // capacity depends on mode: one holding entry or the whole queue
  assign full   = deep_mode ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
  assign empty  = (cnt_q == '0);
  assign take   = pop && !empty;
  assign accept = push_req && (!full || take);
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (accept) wp_d = (wp_q == LAST) ? '0 : wp_q + AW'(1);
    if (take)   rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    unique case ({accept, take})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (accept || take) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (accept) mem[wp_q] <= push_data;
  end

endmodule

// File: rtl/async_tx_bit_timer.sv
module async_tx_bit_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [TW-1:0] slot_len,
  output logic          slot_end
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign slot_end = run && tick && (cnt_q == slot_len - TW'(1));
  assign cnt_en   = restart || (run && tick);

  always_comb begin
    if (restart || slot_end) cnt_d = '0;
    else                     cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int W  = 8,
  parameter int OS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  line_cfg_t    cfg_in,
  input  logic         buf_valid,
  input  logic [W-1:0] buf_data,
  input  logic         cts,
  input  logic         cts_auto,
  input  logic         brk,
  output logic         take,
  output logic         busy,
  output logic         tx_line
);

  localparam int MIN_LEN = W - 3;
  localparam int BW      = $clog2(W);
  localparam int TW      = $clog2(2 * OS + 1);
  localparam logic [TW-1:0] LEN_ONE  = TW'(OS);
  localparam logic [TW-1:0] LEN_HALF = TW'(OS + OS / 2);
  localparam logic [TW-1:0] LEN_TWO  = TW'(2 * OS);

  tx_state_e     st_q, st_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [BW-1:0] left_q, left_d;
  logic          par_q, par_d;
  line_cfg_t     cfg_q, cfg_d;
  logic [TW-1:0] slot_len;
  logic          slot_end, can_go, load, reg_en, line_bit;

  function automatic logic calc_par(input logic [W-1:0] d, input line_cfg_t c);
    logic x;
    x = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < MIN_LEN + int'(c.len_code)) x = x ^ d[i];
    end
    return c.par_even ? x : ~x;
  endfunction

  // start gating: data present and, in auto mode, peer ready
  assign can_go = buf_valid && (!cts_auto || cts);

  always_comb begin
    slot_len = LEN_ONE;
    if (st_q == TX_STOP) begin
      unique case (cfg_q.stop_sel)
        2'd0:    slot_len = LEN_ONE;
        2'd1:    slot_len = LEN_HALF;
        default: slot_len = LEN_TWO;
      endcase
    end
  end

  async_tx_bit_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (busy),
    .restart  (load),
    .slot_len (slot_len),
    .slot_end (slot_end)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    par_d  = par_q;
    cfg_d  = cfg_q;
    load   = 1'b0;
    unique case (st_q)
      TX_IDLE:  if (can_go) load = 1'b1;
      TX_START: if (slot_end) begin
        st_d   = TX_DATA;
        left_d = BW'(MIN_LEN - 1) + BW'(cfg_q.len_code);
      end
      TX_DATA:  if (slot_end) begin
        sh_d = sh_q >> 1;
        if (left_q == '0) st_d = cfg_q.par_en ? TX_PAR : TX_STOP;
        else              left_d = left_q - BW'(1);
      end
      TX_PAR:   if (slot_end) st_d = TX_STOP;
      TX_STOP:  if (slot_end) begin
        if (can_go) load = 1'b1;
        else        st_d = TX_IDLE;
      end
      default:  st_d = TX_IDLE;
    endcase
    if (load) begin
      st_d  = TX_START;
      sh_d  = buf_data;
      cfg_d = cfg_in;
      par_d = calc_par(buf_data, cfg_in);
    end
  end

  assign reg_en = load || slot_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      par_q  <= 1'b0;
      cfg_q  <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      par_q  <= par_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    unique case (st_q)
      TX_START: line_bit = 1'b0;
      TX_DATA:  line_bit = sh_q[0];
      TX_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign take    = load;
  assign busy    = (st_q != TX_IDLE);
  assign tx_line = line_bit & ~brk;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int OS    = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         fifo_mode,
  input  logic [1:0]   len_code,
  input  logic         par_en,
  input  logic         par_even,
  input  logic [1:0]   stop_sel,
  input  logic         brk,
  input  logic         cts,
  input  logic         cts_auto_en,
  output logic         tx_out,
  output logic         thr_empty,
  output logic         tsr_empty
);

  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic         pop, empty, busy;
  logic [W-1:0] buf_data;
  line_cfg_t    cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cfg = '{len_code: len_code, par_en: par_en,
                 par_even: par_even, stop_sel: stop_sel};

  async_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .deep_mode (fifo_mode),
    .push_req  (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .rd_data   (buf_data),
    .empty     (empty)
  );

  async_tx_framer #(.W(W), .OS(OS)) u_frm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick16),
    .cfg_in    (cfg),
    .buf_valid (!empty),
    .buf_data  (buf_data),
    .cts       (cts),
    .cts_auto  (cts_auto_en),
    .brk       (brk),
    .take      (pop),
    .busy      (busy),
    .tx_line   (tx_out)
  );

  assign thr_empty = empty;
  assign tsr_empty = empty && !busy;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic wr_en,
  input logic brk,
  input logic cts,
  input logic cts_auto_en,
  input logic pop,
  input logic tx_out,
  input logic thr_empty,
  input logic tsr_empty
);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tsr_empty && !brk) |-> tx_out);

  assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk && !$past(brk) && !$past(tick16) && !$past(pop)) |-> $stable(tx_out));

  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cts_auto_en) |-> cts);

  assert_break_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_out);

  assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && thr_empty) |=> !thr_empty);

  assert_quiet_implies_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> thr_empty);

endmodule

bind async_tx async_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .wr_en       (wr_en),
  .brk         (brk),
  .cts         (cts),
  .cts_auto_en (cts_auto_en),
  .pop         (pop),
  .tx_out      (tx_out),
  .thr_empty   (thr_empty),
  .tsr_empty   (tsr_empty)
);

// File: tb/sim_async_tx.sv
module sim_async_tx;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DEPTH = 16;

  typedef struct {
    logic [7:0] data;
    logic [1:0] len;
    logic       pe;
    logic       pev;
    logic [1:0] stp;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic fifo_mode = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic par_en = 1'b0;
  logic par_even = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic brk = 1'b0;
  logic cts = 1'b1;
  logic cts_auto_en = 1'b0;
  logic tx_out, thr_empty, tsr_empty;

  int n_chk = 0;
  int n_fail = 0;
  int n_rx = 0;
  int tick_div = 1;
  bit done = 1'b0;
  exp_t exp_q[$];
  int gaps[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_tx #(.W(W), .DEPTH(DEPTH), .OS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .len_code(len_code), .par_en(par_en), .par_even(par_even),
    .stop_sel(stop_sel), .brk(brk), .cts(cts), .cts_auto_en(cts_auto_en),
    .tx_out(tx_out), .thr_empty(thr_empty), .tsr_empty(tsr_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stop_ticks(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic exp_par(input exp_t e);
    logic x = 1'b0;
    for (int i = 0; i < 5 + int'(e.len); i++) x ^= e.data[i];
    return e.pev ? x : ~x;
  endfunction

  // tick generator: driven just after the rising edge
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (cnt <= 0) begin tick16 = 1'b1; cnt = tick_div - 1; end
      else begin tick16 = 1'b0; cnt--; end
    end
  end

  task automatic grab(output logic v);
    do @(negedge clk); while (!(rst_n && tick16 && !brk));
    v = tx_out;
  endtask

  // line monitor: one sample per tick
  initial begin
    int run = 0;
    int prev_stop = 0;
    bit have_prev = 1'b0;
    logic v, first, p;
    exp_t e;
    bit shape_ok;
    logic [7:0] got;
    forever begin
      grab(v);
      if (v) begin run++; continue; end
      if (have_prev) begin
        check(run >= prev_stop, "R4 stop period too short", run, prev_stop);
        gaps.push_back(run);
      end
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected character", 1, 0);
        e = '{data: 8'h00, len: 2'd3, pe: 1'b0, pev: 1'b0, stp: 2'd0};
      end else e = exp_q.pop_front();
      shape_ok = 1'b1;
      for (int i = 0; i < 15; i++) begin grab(v); if (v) shape_ok = 1'b0; end
      got = '0;
      for (int b = 0; b < 5 + int'(e.len); b++) begin
        grab(first);
        got[b] = first;
        for (int i = 0; i < 15; i++) begin grab(v); if (v !== first) shape_ok = 1'b0; end
      end
      if (e.pe) begin
        grab(p);
        for (int i = 0; i < 15; i++) begin grab(v); if (v !== p) shape_ok = 1'b0; end
        check(p === exp_par(e), "R3 parity bit", int'(p), int'(exp_par(e)));
      end
      check(shape_ok, "R2 slot width 16 ticks", 0, 1);
      check(got == (e.data & 8'((1 << (5 + int'(e.len))) - 1)), "R2 data bits",
            int'(got), int'(e.data & 8'((1 << (5 + int'(e.len))) - 1)));
      n_rx++;
      run = 0;
      prev_stop = stop_ticks(e.stp);
      have_prev = 1'b1;
    end
  end

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic pev, input logic [1:0] s);
    @(posedge clk); #1;
    len_code = l; par_en = pe; par_even = pev; stop_sel = s;
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit accepted);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    if (accepted) exp_q.push_back('{data: d, len: len_code, pe: par_en, pev: par_even, stp: stop_sel});
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!tsr_empty);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_start();
    do @(negedge clk); while (tx_out);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(tx_out === 1'b1, "R1 reset tx_out", int'(tx_out), 1);
    check(thr_empty === 1'b1, "R1 reset thr_empty", int'(thr_empty), 1);
    check(tsr_empty === 1'b1, "R1 reset tsr_empty", int'(tsr_empty), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_out === 1'b1, "R1 idle after reset", int'(tx_out), 1);

    // R9 write timing and R6 hold with auto-CTS
    cts_auto_en = 1'b1; cts = 1'b0; fifo_mode = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 2'd0);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = 8'h5A;
    exp_q.push_back('{data: 8'h5A, len: 2'd3, pe: 1'b0, pev: 1'b0, stp: 2'd0});
    @(negedge clk);
    check(thr_empty === 1'b1, "R9 thr_empty before write edge", int'(thr_empty), 1);
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    check(thr_empty === 1'b0, "R9 thr_empty falls after write", int'(thr_empty), 0);
    check(tsr_empty === 1'b0, "R9 tsr_empty falls after write", int'(tsr_empty), 0);
    // R5 holding register: second write while full is dropped
    wr_byte(8'hC3, 1'b0);
    base = n_rx;
    repeat (300) @(negedge clk);
    check(n_rx == base, "R6 no start while cts low", n_rx - base, 0);
    check(tx_out === 1'b1, "R6 line idle while cts low", int'(tx_out), 1);
    @(posedge clk); #1 cts = 1'b1;
    wait_idle();
    check(n_rx == base + 1, "R5 holding mode keeps one byte", n_rx - base, 1);
    check(tsr_empty === 1'b1, "R9 tsr_empty after drain", int'(tsr_empty), 1);

    // R6 auto disabled: cts ignored
    cts_auto_en = 1'b0; cts = 1'b0;
    base = n_rx;
    wr_byte(8'h96, 1'b1);
    wait_idle();
    check(n_rx == base + 1, "R6 cts ignored when auto off", n_rx - base, 1);
    cts = 1'b1;

    // R4 back-to-back stop periods, all settings
    fifo_mode = 1'b1;
    for (int s = 0; s < 3; s++) begin
      set_cfg(2'd0, 1'b1, s[0], 2'(s));
      gaps.delete();
      for (int k = 0; k < 3; k++) wr_byte(8'(8'h31 + 8'(s * 16 + k)), 1'b1);
      wait_idle();
      check(gaps.size() >= 3, "R4 gaps recorded", gaps.size(), 3);
      for (int i = 1; i < gaps.size(); i++)
        check(gaps[i] == stop_ticks(2'(s)), "R4 exact stop length", gaps[i], stop_ticks(2'(s)));
    end

    // R5 FIFO capacity and order, R4 1.5 stop between queued characters
    set_cfg(2'd3, 1'b1, 1'b1, 2'd1);
    cts_auto_en = 1'b1; cts = 1'b0;
    for (int k = 0; k < DEPTH + 1; k++) wr_byte(8'(k * 37 + 5), k < DEPTH);
    @(negedge clk);
    check(thr_empty === 1'b0, "R9 queue holds data", int'(thr_empty), 0);
    base = n_rx;
    gaps.delete();
    @(posedge clk); #1 cts = 1'b1;
    wait_idle();
    check(n_rx == base + DEPTH, "R5 FIFO delivers DEPTH bytes", n_rx - base, DEPTH);
    for (int i = 1; i < gaps.size(); i++)
      check(gaps[i] == 24, "R4 one-and-half stop gap", gaps[i], 24);

    // R7 cts drop mid-character
    set_cfg(2'd3, 1'b0, 1'b0, 2'd0);
    base = n_rx;
    wr_byte(8'hE1, 1'b1);
    wr_byte(8'h1E, 1'b1);
    wait_start();
    repeat (40) @(posedge clk);
    #1 cts = 1'b0;
    repeat (600) @(negedge clk);
    check(n_rx == base + 1, "R7 current character completes", n_rx - base, 1);
    check(thr_empty === 1'b0, "R7 next character held", int'(thr_empty), 0);
    check(tx_out === 1'b1, "R7 line marking while held", int'(tx_out), 1);
    @(posedge clk); #1 cts = 1'b1;
    wait_idle();
    check(n_rx == base + 2, "R7 held character sent", n_rx - base, 2);

    // R10 settings captured at start
    base = n_rx;
    wr_byte(8'hA5, 1'b1);
    wait_start();
    @(negedge clk);
    check(thr_empty === 1'b1 && tsr_empty === 1'b0, "R9 shifting with empty buffer",
          int'({thr_empty, tsr_empty}), 2);
    set_cfg(2'd0, 1'b1, 1'b1, 2'd2);
    wait_idle();
    check(n_rx == base + 1, "R10 character sent with captured settings", n_rx - base, 1);

    // R8 break
    @(posedge clk); #1 brk = 1'b1;
    @(negedge clk);
    check(tx_out === 1'b0, "R8 break forces spacing", int'(tx_out), 0);
    @(posedge clk); #1 brk = 1'b0;
    @(negedge clk);
    check(tx_out === 1'b1, "R8 line marking after break", int'(tx_out), 1);

    // random batches, fixed seed
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1CE5);
    end
    for (int b = 0; b < 8; b++) begin
      set_cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      fifo_mode = 1'($urandom_range(0, 1));
      cts_auto_en = 1'($urandom_range(0, 1));
      tick_div = $urandom_range(1, 3);
      for (int k = 0; k < 5; k++) begin
        wr_byte(8'($urandom), 1'b1);
        if (!fifo_mode) begin
          do @(negedge clk); while (!thr_empty);
        end
      end
      wait_idle();
    end
    tick_div = 1;
    check(exp_q.size() == 0, "R2 every queued character delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule